// File: doc/BRIEF.md
# Quasi-random level hypervector encoder

This block turns one image into a stream of level hypervectors for hyperdimensional training without any position hypervector. Every pixel owns a private stored sequence of D quantized quasi-random numbers, chosen by the pixel's index. The pixel's M-bit intensity is compared against each number of that sequence. Each comparison yields one hypervector dimension: +1 (logic-1) when the intensity is at least the sequence number, and -1 (logic-0) otherwise. Because the pixel index already selects a distinct sequence, no binding step and no pseudo-random generator are needed. The resulting D-bit vector can feed the per-dimension accumulators directly.

Software or a loader first fills two stores. The pixel intensities go into a small register file, and the H×D sequence numbers go into a synchronous-read memory. Software then pulses start. The block visits the pixels in ascending order and reads one sequence number per cycle. Each comparison uses unary (thermometer) streams rather than a binary magnitude comparator. After the last dimension of a pixel, the block presents that pixel's complete vector for one cycle. A single-cycle done pulse closes the pass. The pass is deterministic and runs once, with no regeneration.

Top module: `hdc_ld_level_enc`

## Requirements
- R1: While reset is held and just after it is released, busy, done and lvl_valid are all low.
- R2: Bit d of lvl_vec is 1 exactly when the pixel's M-bit intensity, taken as unsigned, is greater than or equal to the M-bit sequence number for dimension d. Otherwise the bit is 0.
- R3: Pixel i uses the sequence numbers stored at seq_addr = i·D + d, for d = 0..D-1. The strobes come out in ascending pixel order, and lvl_pix carries the index of the pixel whose vector is shown.
- R4: A pass produces exactly H strobes of lvl_valid, each one cycle long, and consecutive strobes are exactly D cycles apart. Count the rising edge that samples start as edge 1. The first strobe is then visible after rising edge D+2.
- R5: done is a single-cycle pulse that appears one cycle after the strobe of pixel H-1. busy is high from the cycle after start is accepted until done rises, and busy is low while done is high.
- R6: A start pulse while busy is high is ignored: the running pass keeps its order, timing and results, and no second pass follows it.
- R7: An intensity of 2^M-1 gives an all-ones vector. An intensity of 0 gives ones only in the dimensions whose sequence number is 0.
- R8: A new pass can start in the cycle done is high. The new pass reflects the current contents of both stores, including sequence numbers rewritten between passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a pass; accepted only while idle |
| pix_we | input | 1 | Pixel register write enable |
| pix_addr | input | $clog2(H) | Pixel index to write |
| pix_data | input | M | Quantized pixel intensity |
| seq_we | input | 1 | Sequence memory write enable |
| seq_addr | input | $clog2(H·D) | Sequence memory address, i·D + d |
| seq_data | input | M | Quantized sequence number |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| lvl_valid | output | 1 | One-cycle strobe: lvl_vec holds a pixel's level vector |
| lvl_pix | output | $clog2(H) | Index of the pixel whose vector is shown |
| lvl_vec | output | D | Level hypervector, bit d for dimension d |

## Verification
The bench targets the comparison at equality and at the extremes: intensity 0 against sequence numbers of 0, and intensity 15 against every value. A comparator with a strict inequality, or with swapped operands, would flip exactly those bits. It measures the latency to the first strobe and the spacing between strobes. A read pipeline that is off by one stage would shift bits between dimensions or push a strobe a cycle early or late. It injects a start pulse in the middle of a pass. A controller that restarted would repeat pixel 0 or run a second pass. It also rewrites the sequence memory and restarts in the done cycle. A design that cached old contents or dropped that start would return stale or missing vectors.

// File: rtl/hdc_enc_pkg.sv
package hdc_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FLUSH = 2'd2
  } enc_state_e;
endpackage

// File: rtl/hdc_pix_regs.sv
module hdc_pix_regs #(
  parameter int H = 16,
  parameter int M = 4,
  localparam int PW = $clog2(H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [M-1:0]  wr_val,
  input  logic [PW-1:0] rd_idx,
  output logic [M-1:0]  rd_val
);
  logic [M-1:0] val_q [H];

  for (genvar g = 0; g < H; g++) begin : g_pix
    logic en;
    assign en = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q[g] <= '0;
      else if (en) val_q[g] <= wr_val;
    end
  end

  assign rd_val = val_q[rd_idx];
endmodule

// File: rtl/hdc_seq_ram.sv
module hdc_seq_ram #(
  parameter int H = 16,
  parameter int D = 64,
  parameter int M = 4,
  localparam int DEPTH = H * D,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [M-1:0]  wr_val,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [M-1:0]  rd_val
);
  logic [M-1:0] mem [DEPTH];
  logic [M-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_val = rd_q;
endmodule

// File: rtl/hdc_unary_ge.sv
module hdc_unary_ge #(
  parameter int M = 4,
  localparam int L = 1 << M
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         ge
);
  logic [L-1:0] ua, ub, low;

  // thermometer streams: bit k is set when the value exceeds k
  for (genvar k = 0; k < L; k++) begin : g_therm
    assign ua[k] = (a > M'(k));
    assign ub[k] = (b > M'(k));
  end

  // AND of two aligned streams is the smaller value; it equals b iff a >= b
  assign low = ua & ub;
  assign ge  = &(low | ~ub);

  always_comb begin
    a_r2_unary_matches: assert (ge == (a >= b));
  end
endmodule

// File: rtl/hdc_lvl_ctrl.sv
module hdc_lvl_ctrl
  import hdc_enc_pkg::*;
#(
  parameter int H = 16,
  parameter int D = 64,
  localparam int PW = $clog2(H),
  localparam int DW = $clog2(D),
  localparam int AW = $clog2(H * D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  output logic          busy,
  output logic          done,
  output logic          iss_vld,
  output logic [AW-1:0] iss_addr,
  output logic          s1_vld,
  output logic [PW-1:0] s1_pix,
  output logic [DW-1:0] s1_dim,
  output logic          s1_last
);
  enc_state_e    st_q, st_d;
  logic [PW-1:0] pix_q, pix_d;
  logic [DW-1:0] dim_q, dim_d;
  logic          done_q, done_d;
  logic          s1_vld_q, s1_last_q;
  logic [PW-1:0] s1_pix_q;
  logic [DW-1:0] s1_dim_q;
  logic          dim_end;

  assign dim_end = (dim_q == DW'(D - 1));

  always_comb begin
    st_d   = st_q;
    pix_d  = pix_q;
    dim_d  = dim_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_ISSUE;
          pix_d = '0;
          dim_d = '0;
        end
      end
      ST_ISSUE: begin
        if (dim_end) begin
          dim_d = '0;
          if (pix_q == PW'(H - 1)) st_d = ST_FLUSH;
          else                     pix_d = pix_q + PW'(1);
        end else begin
          dim_d = dim_q + DW'(1);
        end
      end
      ST_FLUSH: begin
        if (fin) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pix_q  <= '0;
      dim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pix_q  <= pix_d;
      dim_q  <= dim_d;
      done_q <= done_d;
    end
  end

  assign iss_vld  = (st_q == ST_ISSUE);
  assign iss_addr = AW'(pix_q) * AW'(D) + AW'(dim_q);

  // tags travel alongside the one-cycle memory read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_pix_q  <= '0;
      s1_dim_q  <= '0;
      s1_last_q <= 1'b0;
    end else begin
      s1_vld_q <= iss_vld;
      if (iss_vld) begin
        s1_pix_q  <= pix_q;
        s1_dim_q  <= dim_q;
        s1_last_q <= dim_end;
      end
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign s1_vld  = s1_vld_q;
  assign s1_pix  = s1_pix_q;
  assign s1_dim  = s1_dim_q;
  assign s1_last = s1_last_q;

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(fin));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start) |=> !(st_q == ST_ISSUE && pix_q == '0 && dim_q == '0));
endmodule

// File: rtl/hdc_lvl_assemble.sv
module hdc_lvl_assemble #(
  parameter int H = 16,
  parameter int D = 64,
  localparam int PW = $clog2(H),
  localparam int DW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_vld,
  input  logic [PW-1:0] s1_pix,
  input  logic [DW-1:0] s1_dim,
  input  logic          s1_last,
  input  logic          ge,
  output logic          lvl_valid,
  output logic [PW-1:0] lvl_pix,
  output logic [D-1:0]  lvl_vec
);
  logic [D-1:0]  build_q, build_d;
  logic [D-1:0]  vec_q;
  logic [PW-1:0] pix_q;
  logic          vld_q;
  logic          emit;

  always_comb begin
    build_d         = build_q;
    build_d[s1_dim] = ge;
  end

  assign emit = s1_vld && s1_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      build_q <= '0;
    else if (s1_vld) build_q <= build_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pix_q <= '0;
    end else if (emit) begin
      vec_q <= build_d;
      pix_q <= s1_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= emit;
  end

  assign lvl_valid = vld_q;
  assign lvl_pix   = pix_q;
  assign lvl_vec   = vec_q;

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  a_r3_strobe_follows_last_dim: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(s1_vld) && $past(s1_dim) == DW'(D - 1)));
endmodule

// File: rtl/hdc_ld_level_enc.sv
module hdc_ld_level_enc #(
  parameter int H = 16,
  parameter int D = 64,
  parameter int M = 4,
  localparam int PW = $clog2(H),
  localparam int DW = $clog2(D),
  localparam int AW = $clog2(H * D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pix_we,
  input  logic [PW-1:0] pix_addr,
  input  logic [M-1:0]  pix_data,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [M-1:0]  seq_data,
  output logic          busy,
  output logic          done,
  output logic          lvl_valid,
  output logic [PW-1:0] lvl_pix,
  output logic [D-1:0]  lvl_vec
);
  logic          rst_m_q, rst_s_q;
  logic          iss_vld;
  logic [AW-1:0] iss_addr;
  logic          s1_vld, s1_last;
  logic [PW-1:0] s1_pix;
  logic [DW-1:0] s1_dim;
  logic [M-1:0]  pix_val, seq_val;
  logic          ge, fin;

  // reset asserts at once and releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  hdc_pix_regs #(.H(H), .M(M)) u_pix (
    .clk(clk), .rst_n(rst_s_q),
    .wr_en(pix_we), .wr_idx(pix_addr), .wr_val(pix_data),
    .rd_idx(s1_pix), .rd_val(pix_val)
  );

  hdc_seq_ram #(.H(H), .D(D), .M(M)) u_seq (
    .clk(clk),
    .wr_en(seq_we), .wr_addr(seq_addr), .wr_val(seq_data),
    .rd_en(iss_vld), .rd_addr(iss_addr), .rd_val(seq_val)
  );

  hdc_lvl_ctrl #(.H(H), .D(D)) u_ctrl (
    .clk(clk), .rst_n(rst_s_q), .start(start), .fin(fin),
    .busy(busy), .done(done),
    .iss_vld(iss_vld), .iss_addr(iss_addr),
    .s1_vld(s1_vld), .s1_pix(s1_pix), .s1_dim(s1_dim), .s1_last(s1_last)
  );

  hdc_unary_ge #(.M(M)) u_cmp (
    .a(pix_val), .b(seq_val), .ge(ge)
  );

  hdc_lvl_assemble #(.H(H), .D(D)) u_asm (
    .clk(clk), .rst_n(rst_s_q),
    .s1_vld(s1_vld), .s1_pix(s1_pix), .s1_dim(s1_dim), .s1_last(s1_last),
    .ge(ge),
    .lvl_valid(lvl_valid), .lvl_pix(lvl_pix), .lvl_vec(lvl_vec)
  );

  assign fin = lvl_valid && (lvl_pix == PW'(H - 1));

  a_r5_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_s_q)
    done |-> !busy);
  a_r4_strobe_only_when_busy: assert property (@(posedge clk) disable iff (!rst_s_q)
    lvl_valid |-> busy);
endmodule

// File: tb/hdc_ld_level_enc_test.sv
module hdc_ld_level_enc_test;
  localparam int H = 16;
  localparam int D = 64;
  localparam int M = 4;
  localparam int PW = $clog2(H);
  localparam int AW = $clog2(H * D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          pix_we = 1'b0;
  logic [PW-1:0] pix_addr = '0;
  logic [M-1:0]  pix_data = '0;
  logic          seq_we = 1'b0;
  logic [AW-1:0] seq_addr = '0;
  logic [M-1:0]  seq_data = '0;
  logic          busy, done, lvl_valid;
  logic [PW-1:0] lvl_pix;
  logic [D-1:0]  lvl_vec;

  int errors = 0;
  int checks = 0;
  logic [M-1:0] pix_m [H];
  logic [M-1:0] seq_m [H*D];

  always #10 clk = ~clk;

  hdc_ld_level_enc #(.H(H), .D(D), .M(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
    .seq_we(seq_we), .seq_addr(seq_addr), .seq_data(seq_data),
    .busy(busy), .done(done), .lvl_valid(lvl_valid),
    .lvl_pix(lvl_pix), .lvl_vec(lvl_vec)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [D-1:0] exp_vec(input int p);
    logic [D-1:0] v;
    for (int d = 0; d < D; d++) v[d] = (pix_m[p] >= seq_m[p*D + d]);
    return v;
  endfunction

  task automatic load_pix(input int mode);
    for (int i = 0; i < H; i++) begin
      case (mode)
        0: pix_m[i] = M'(i);
        1: pix_m[i] = (i % 2 == 0) ? M'(0) : M'(15);
        default: pix_m[i] = M'((i * 11 + 3) % 16);
      endcase
      @(negedge clk);
      pix_we = 1'b1; pix_addr = PW'(i); pix_data = pix_m[i];
    end
    @(negedge clk); pix_we = 1'b0;
  endtask

  task automatic load_seq(input int mode);
    for (int a = 0; a < H*D; a++) begin
      int i = a / D;
      int d = a % D;
      case (mode)
        0: seq_m[a] = M'((i * 7 + d * 3) % 16);
        1: seq_m[a] = M'((d * 5 + i) % 16);
        default: seq_m[a] = M'((d ^ (i * 3)) % 16);
      endcase
      @(negedge clk);
      seq_we = 1'b1; seq_addr = AW'(a); seq_data = seq_m[a];
    end
    @(negedge clk); seq_we = 1'b0;
  endtask

  // runs one pass from the current negedge; inject > 0 pulses start at that cycle
  task automatic run_pass(input string req, input int inject);
    int cyc = 1;
    int nstrobe = 0;
    int prev = 0;
    int last_cyc = 0;
    bit seen_done = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R5", "busy after start", busy, 1);
    while (!seen_done && cyc < H*D + 200) begin
      @(negedge clk); cyc++;
      start = (inject > 0 && cyc == inject);
      if (lvl_valid) begin
        if (nstrobe == 0)
          check(cyc == D + 2, "R4", "first strobe edge", cyc, D + 2);
        else
          check(cyc - prev == D, "R4", "strobe spacing", cyc - prev, D);
        check(lvl_pix == PW'(nstrobe), "R3", "pixel order", lvl_pix, nstrobe);
        if (nstrobe < H)
          check(lvl_vec == exp_vec(nstrobe), req, "level vector",
                longint'(lvl_vec), longint'(exp_vec(nstrobe)));
        prev = cyc; last_cyc = cyc; nstrobe++;
      end
      if (done) begin
        seen_done = 1;
        check(cyc == last_cyc + 1, "R5", "done after last strobe", cyc, last_cyc + 1);
        check(busy === 1'b0, "R5", "busy low with done", busy, 0);
      end
    end
    start = 1'b0;
    check(seen_done, "R5", "done seen", seen_done, 1);
    check(nstrobe == H, "R4", "strobe count", nstrobe, H);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0 && lvl_valid === 1'b0, "R1",
          "outputs in reset", {busy, done, lvl_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && lvl_valid === 1'b0, "R1",
          "outputs after reset", {busy, done, lvl_valid}, 0);
  endtask

  task automatic t_basic();
    load_pix(0); load_seq(0);
    run_pass("R2", 0);
  endtask

  task automatic t_extremes();
    load_pix(1); load_seq(1);
    run_pass("R7", 0);
  endtask

  task automatic t_ignored_start();
    int extra = 0;
    @(negedge clk);
    run_pass("R6", 100);
    repeat (D + 10) begin
      @(negedge clk);
      if (lvl_valid || busy) extra++;
    end
    check(extra == 0, "R6", "no second pass", extra, 0);
  endtask

  task automatic t_reload_restart();
    load_pix(2); load_seq(2);
    run_pass("R8", 0);
    // new start in the done cycle, after rewriting one pixel's sequence
    for (int d = 0; d < D; d++) seq_m[3*D + d] = M'(15 - (d % 16));
    for (int d = 0; d < D; d++) begin
      @(negedge clk);
      seq_we = 1'b1; seq_addr = AW'(3*D + d); seq_data = seq_m[3*D + d];
    end
    @(negedge clk); seq_we = 1'b0;
    run_pass("R8", 0);
    run_pass("R8", 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_extremes();
    t_ignored_start();
    t_reload_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule